// File: doc/BRIEF.md
# Display FIFO Fill Request Controller

This block sits beside a display pixel FIFO of 64-bit entries and decides when that FIFO should ask the memory controller for more data. It keeps its own count of how many entries the FIFO holds, using the push strobes from the memory return path and the pop strobes from the pixel consumer. It also keeps the write and read pointers that the FIFO storage uses. As long as there is room, it raises an ordinary fill request.

When the FIFO runs low, the block raises an urgent request. Two 4-bit fields, each counted in units of four entries, set the window. The urgent request starts once the fill level has dropped to the low mark. It then stays up until the level has climbed back to the high mark, so the priority does not toggle on every entry. If software programs a high mark that is not above the low mark, each urgent request ends on the first grant from the memory controller, so the request can never stay up for good.

A diagnostic enable lets test logic reach the FIFO directly. When the enable rises, the pointers and the level are cleared. While the enable stays high, no memory requests are issued.

Top module: `dfifo_fill_ctrl`

## Requirements
- R1: After reset, `level_o`, `wr_ptr_o` and `rd_ptr_o` are 0, `empty_o` is 1, `full_o` is 0, `hipri_o` is 0, and `fill_req_o` is 1 while `diag_en_i` is low.
- R2: At a clock edge, an accepted push adds one to `level_o` and advances `wr_ptr_o` by one. An accepted pop subtracts one from `level_o` and advances `rd_ptr_o` by one. When both are accepted at the same edge, the level is unchanged and both pointers advance.
- R3: A push while `full_o` is high (level 64) is ignored, and so is a pop while `empty_o` is high (level 0). The other strobe at that same edge still acts, and the level never wraps.
- R4: `wr_ptr_o` and `rd_ptr_o` count modulo the FIFO depth of 64, so they return to 0 after entry 63.
- R5: `fill_req_o` is high exactly when `diag_en_i` is low and the level is below 64.
- R6: Suppose that, at a clock edge, the urgent request is inactive, `diag_en_i` is low and `level_o` is at or below 4×`prio_start_i`. Then `hipri_o` is high after that edge.
- R7: When 4×`prio_end_i` is greater than 4×`prio_start_i`, an active `hipri_o` stays high at every edge where `level_o` is below 4×`prio_end_i`, whatever `grant_i` does. It drops at the first edge where `level_o` is at or above that mark.
- R8: When 4×`prio_end_i` is not above 4×`prio_start_i`, an active `hipri_o` drops at the first edge where `grant_i` is high.
- R9: At the edge where `diag_en_i` is first seen high after being low, `level_o`, `wr_ptr_o` and `rd_ptr_o` become 0, and any push or pop at that edge is discarded. While `diag_en_i` stays high, push and pop work as in R2.
- R10: While `diag_en_i` is high, `fill_req_o` and `hipri_o` are low and the urgent state is cleared, so it is decided again from R6 once the enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | FIFO write strobe (entry arrives from memory) |
| pop_i | input | 1 | FIFO read strobe (pixel consumer takes an entry) |
| prio_start_i | input | 4 | Urgent-request low mark, in units of 4 entries |
| prio_end_i | input | 4 | Urgent-request high mark, in units of 4 entries |
| grant_i | input | 1 | Memory controller accepted a request |
| diag_en_i | input | 1 | Diagnostic enable; rising edge clears pointers |
| fill_req_o | output | 1 | Ordinary fill request |
| hipri_o | output | 1 | Urgent fill request |
| level_o | output | 7 | Entries currently held |
| wr_ptr_o | output | 6 | FIFO write pointer |
| rd_ptr_o | output | 6 | FIFO read pointer |
| full_o | output | 1 | Level equals depth |
| empty_o | output | 1 | Level equals zero |

## Verification
Two kinds of clash can land on the same clock edge. A boundary strobe can meet its counterpart: a push while full arrives together with a pop, or a pop while empty arrives together with a push. The rising edge of the diagnostic enable can also meet a push. Each clash is provoked by driving both strobes in the same cycle. The result is judged by whether only the legal strobe moved the level and pointers, or whether the diagnostic clear won and the push was dropped. The hysteresis is checked by walking the level up and down through both marks, with grants in between, under both a proper window and an inverted one.

// File: rtl/dfifo_fill_pkg.sv
package dfifo_fill_pkg;

  typedef enum logic [0:0] {
    PRIO_IDLE   = 1'b0,
    PRIO_URGENT = 1'b1
  } prio_state_e;

  // Scale a threshold field into an entry count of the given width.
  function automatic int unsigned scaled_mark(input int unsigned field, input int unsigned unit);
    return field * unit;
  endfunction

endpackage

// File: rtl/dfifo_edge_rise.sv
module dfifo_edge_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= 1'b0;
    end else begin
      sig_q <= sig_i;
    end
  end

  assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/dfifo_level_track.sv
module dfifo_level_track #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             clear_i,
  output logic [LVL_W-1:0] level_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             full_o,
  output logic             empty_o
);

  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);
  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [PTR_W-1:0] wr_inc, rd_inc;
  logic             push_ok, pop_ok;
  logic             lvl_en, wr_en, rd_en;

  assign full_o  = (lvl_q == DEPTH_L);
  assign empty_o = (lvl_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  // Pointer increment: natural wrap for power-of-two depths, explicit otherwise.
  generate
    if (POW2) begin : g_wrap_pow2
      assign wr_inc = wr_q + PTR_W'(1);
      assign rd_inc = rd_q + PTR_W'(1);
    end else begin : g_wrap_cmp
      assign wr_inc = (wr_q == LAST_P) ? '0 : wr_q + PTR_W'(1);
      assign rd_inc = (rd_q == LAST_P) ? '0 : rd_q + PTR_W'(1);
    end
  endgenerate

  always_comb begin
    lvl_d  = lvl_q;
    wr_d   = wr_q;
    rd_d   = rd_q;
    lvl_en = 1'b0;
    wr_en  = 1'b0;
    rd_en  = 1'b0;
    if (clear_i) begin
      lvl_d  = '0;
      wr_d   = '0;
      rd_d   = '0;
      lvl_en = 1'b1;
      wr_en  = 1'b1;
      rd_en  = 1'b1;
    end else begin
      if (push_ok) begin
        wr_d  = wr_inc;
        wr_en = 1'b1;
      end
      if (pop_ok) begin
        rd_d  = rd_inc;
        rd_en = 1'b1;
      end
      case ({push_ok, pop_ok})
        2'b10: begin
          lvl_d  = lvl_q + LVL_W'(1);
          lvl_en = 1'b1;
        end
        2'b01: begin
          lvl_d  = lvl_q - LVL_W'(1);
          lvl_en = 1'b1;
        end
        default: begin
          lvl_d  = lvl_q;
          lvl_en = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (lvl_en) lvl_q <= lvl_d;
      if (wr_en)  wr_q  <= wr_d;
      if (rd_en)  rd_q  <= rd_d;
    end
  end

  assign level_o  = lvl_q;
  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;

endmodule

// File: rtl/dfifo_prio_fsm.sv
module dfifo_prio_fsm
  import dfifo_fill_pkg::*;
#(
  parameter int unsigned LVL_W   = 7,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned UNIT    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   level_i,
  input  logic [FIELD_W-1:0] start_i,
  input  logic [FIELD_W-1:0] end_i,
  input  logic               grant_i,
  input  logic               quiet_i,
  output logic               hipri_o
);

  localparam logic [LVL_W-1:0] UNIT_L = LVL_W'(scaled_mark(1, UNIT));

  prio_state_e      state_q, state_d;
  logic [LVL_W-1:0] start_mark, end_mark;
  logic             window_ok, leave_urgent;

  assign start_mark   = LVL_W'(start_i) * UNIT_L;
  assign end_mark     = LVL_W'(end_i) * UNIT_L;
  assign window_ok    = (end_mark > start_mark);
  assign leave_urgent = window_ok ? (level_i >= end_mark) : grant_i;

  always_comb begin
    state_d = state_q;
    if (quiet_i) begin
      state_d = PRIO_IDLE;
    end else begin
      case (state_q)
        PRIO_IDLE:   if (level_i <= start_mark) state_d = PRIO_URGENT;
        PRIO_URGENT: if (leave_urgent)          state_d = PRIO_IDLE;
        default:                                state_d = PRIO_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PRIO_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign hipri_o = (state_q == PRIO_URGENT) & ~quiet_i;

endmodule

// File: rtl/dfifo_fill_ctrl.sv
module dfifo_fill_ctrl #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned UNIT    = 4,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic [FIELD_W-1:0] prio_start_i,
  input  logic [FIELD_W-1:0] prio_end_i,
  input  logic               grant_i,
  input  logic               diag_en_i,
  output logic               fill_req_o,
  output logic               hipri_o,
  output logic [LVL_W-1:0]   level_o,
  output logic [PTR_W-1:0]   wr_ptr_o,
  output logic [PTR_W-1:0]   rd_ptr_o,
  output logic               full_o,
  output logic               empty_o
);

  logic diag_rise;

  dfifo_edge_rise u_diag_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (diag_en_i),
    .rise_o (diag_rise)
  );

  dfifo_level_track #(
    .DEPTH (DEPTH)
  ) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .clear_i  (diag_rise),
    .level_o  (level_o),
    .wr_ptr_o (wr_ptr_o),
    .rd_ptr_o (rd_ptr_o),
    .full_o   (full_o),
    .empty_o  (empty_o)
  );

  dfifo_prio_fsm #(
    .LVL_W   (LVL_W),
    .FIELD_W (FIELD_W),
    .UNIT    (UNIT)
  ) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (level_o),
    .start_i (prio_start_i),
    .end_i   (prio_end_i),
    .grant_i (grant_i),
    .quiet_i (diag_en_i),
    .hipri_o (hipri_o)
  );

  assign fill_req_o = ~diag_en_i & ~full_o;

endmodule

// File: rtl/dfifo_fill_ctrl_chk.sv
module dfifo_fill_ctrl_chk #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned UNIT    = 4,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               push_i,
  input logic               pop_i,
  input logic [FIELD_W-1:0] prio_start_i,
  input logic [FIELD_W-1:0] prio_end_i,
  input logic               grant_i,
  input logic               diag_en_i,
  input logic               fill_req_o,
  input logic               hipri_o,
  input logic [LVL_W-1:0]   level_o,
  input logic [PTR_W-1:0]   wr_ptr_o,
  input logic [PTR_W-1:0]   rd_ptr_o,
  input logic               full_o,
  input logic               empty_o
);

  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] UNIT_L  = LVL_W'(UNIT);

  logic             diag_seen;
  logic [LVL_W-1:0] s_mark, e_mark;

  assign s_mark = LVL_W'(prio_start_i) * UNIT_L;
  assign e_mark = LVL_W'(prio_end_i) * UNIT_L;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) diag_seen <= 1'b0;
    else        diag_seen <= diag_en_i;
  end

  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= DEPTH_L);

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i && !diag_en_i) |=> (level_o == DEPTH_L));

  p_empty_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i && !diag_en_i) |=> (level_o == '0));

  p_req_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !fill_req_o);

  p_hipri_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!diag_en_i && (level_o <= s_mark) && !(hipri_o && grant_i)) |=> (hipri_o || diag_en_i));

  p_hipri_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hipri_o && (e_mark > s_mark) && (level_o < e_mark)) |=> (hipri_o || diag_en_i));

  p_hipri_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hipri_o && !(e_mark > s_mark) && grant_i) |=> !hipri_o);

  p_diag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_en_i && !diag_seen) |=> (level_o == '0 && wr_ptr_o == '0 && rd_ptr_o == '0));

  p_diag_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    diag_en_i |-> (!fill_req_o && !hipri_o));

  always_comb begin
    if (rst_n) begin
      a_flags_r1: assert (!(full_o && empty_o));
    end
  end

endmodule

bind dfifo_fill_ctrl dfifo_fill_ctrl_chk #(
  .DEPTH   (DEPTH),
  .FIELD_W (FIELD_W),
  .UNIT    (UNIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .prio_start_i (prio_start_i),
  .prio_end_i   (prio_end_i),
  .grant_i      (grant_i),
  .diag_en_i    (diag_en_i),
  .fill_req_o   (fill_req_o),
  .hipri_o      (hipri_o),
  .level_o      (level_o),
  .wr_ptr_o     (wr_ptr_o),
  .rd_ptr_o     (rd_ptr_o),
  .full_o       (full_o),
  .empty_o      (empty_o)
);

// File: tb/dfifo_fill_ctrl_bench.sv
module dfifo_fill_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  typedef struct {
    int    lvl;
    int    wr;
    int    rd;
    bit    req;
    bit    hp;
    bit    full;
    bit    empty;
    string tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       push, pop, grant, diag;
  logic [3:0] st, en;
  logic       fill_req, hipri, full, empty;
  logic [6:0] level;
  logic [5:0] wr_ptr, rd_ptr;

  int checks;
  int errors;
  bit done;
  exp_t exp_q[$];

  // Reference state
  int m_lvl, m_wr, m_rd;
  bit m_hp, m_dq;
  logic [3:0] want_st, want_en;

  dfifo_fill_ctrl u_dfifo_fill_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push),
    .pop_i        (pop),
    .prio_start_i (st),
    .prio_end_i   (en),
    .grant_i      (grant),
    .diag_en_i    (diag),
    .fill_req_o   (fill_req),
    .hipri_o      (hipri),
    .level_o      (level),
    .wr_ptr_o     (wr_ptr),
    .rd_ptr_o     (rd_ptr),
    .full_o       (full),
    .empty_o      (empty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic void compare(input exp_t e);
    checks++;
    if (int'(level) != e.lvl || int'(wr_ptr) != e.wr || int'(rd_ptr) != e.rd ||
        fill_req !== e.req || hipri !== e.hp || full !== e.full || empty !== e.empty) begin
      errors++;
      $display("FAIL %s: got lvl=%0d wr=%0d rd=%0d req=%0b hp=%0b full=%0b empty=%0b, expected lvl=%0d wr=%0d rd=%0d req=%0b hp=%0b full=%0b empty=%0b",
               e.tag, level, wr_ptr, rd_ptr, fill_req, hipri, full, empty,
               e.lvl, e.wr, e.rd, e.req, e.hp, e.full, e.empty);
    end
  endfunction

  // Driver: applies one cycle of stimulus and predicts the state after the edge.
  task automatic step(input bit p, input bit q, input bit d, input bit g, input string tag);
    exp_t e;
    int s4, e4;
    bit rise, pok, qok, hp_n;
    @(negedge clk);
    st = want_st; en = want_en;
    push = p; pop = q; diag = d; grant = g;
    s4 = int'(want_st) * 4;
    e4 = int'(want_en) * 4;
    rise = d && !m_dq;
    if (d) hp_n = 1'b0;
    else if (m_hp) hp_n = (e4 > s4) ? !(m_lvl >= e4) : !g;
    else hp_n = (m_lvl <= s4);
    if (rise) begin
      m_lvl = 0; m_wr = 0; m_rd = 0;
    end else begin
      pok = p && (m_lvl < DEPTH);
      qok = q && (m_lvl > 0);
      if (pok) m_wr = (m_wr + 1) % DEPTH;
      if (qok) m_rd = (m_rd + 1) % DEPTH;
      m_lvl = m_lvl + int'(pok) - int'(qok);
    end
    m_hp = hp_n;
    m_dq = d;
    e.lvl = m_lvl; e.wr = m_wr; e.rd = m_rd;
    e.req = !d && (m_lvl < DEPTH);
    e.hp = m_hp && !d;
    e.full = (m_lvl == DEPTH);
    e.empty = (m_lvl == 0);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares each predicted result just after the edge that makes it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    push = 0; pop = 0; grant = 0; diag = 0;
    st = 4'd2; en = 4'd5; want_st = 4'd2; want_en = 4'd5;
    m_lvl = 0; m_wr = 0; m_rd = 0; m_hp = 0; m_dq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (level !== 7'd0 || wr_ptr !== 6'd0 || rd_ptr !== 6'd0 || empty !== 1'b1 ||
        full !== 1'b0 || hipri !== 1'b0 || fill_req !== 1'b1) begin
      errors++;
      $display("FAIL R1: got lvl=%0d wr=%0d rd=%0d empty=%0b full=%0b hp=%0b req=%0b, expected 0 0 0 1 0 0 1",
               level, wr_ptr, rd_ptr, empty, full, hipri, fill_req);
    end

    // Low mark 8, high mark 20
    step(0, 0, 0, 0, "R6");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R2");
    step(0, 1, 0, 0, "R2");
    step(1, 1, 0, 0, "R2");
    step(0, 0, 0, 1, "R7");
    for (int i = 0; i < 16; i++) step(1, 0, 0, (i % 3) == 0, "R7");
    step(0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, "R7");
    // Fill to the top; the write pointer wraps
    while (m_lvl < DEPTH) step(1, 0, 0, 0, "R4");
    step(0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, "R3");
    step(1, 0, 0, 0, "R3");
    step(1, 1, 0, 0, "R3");
    step(1, 0, 0, 0, "R5");
    // Drain; urgent request rises again at the low mark
    while (m_lvl > 0) step(0, 1, 0, 0, "R6");
    step(0, 1, 0, 0, "R3");
    step(1, 1, 0, 0, "R3");
    step(0, 0, 0, 0, "R4");
    // Inverted window: grant ends the urgent request
    want_st = 4'd5; want_en = 4'd3;
    step(1, 0, 0, 0, "R8");
    step(0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, "R8");
    step(1, 0, 0, 0, "R8");
    // Diagnostic clear collides with a push
    want_st = 4'd2; want_en = 4'd5;
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0, "R2");
    step(1, 0, 1, 0, "R9");
    step(1, 0, 1, 0, "R9");
    step(1, 1, 1, 0, "R10");
    step(0, 0, 1, 1, "R10");
    step(0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, "R2");
    wait (exp_q.size() == 0);
    @(negedge clk);
    finish_run();
  end

endmodule